// File: doc/BRIEF.md
# IR Run-Length Decoder

This block takes the byte stream of a consumer-IR receiver that samples its input line at a fixed rate. Each byte holds eight line samples, and the samples arrive inverted. The block turns those samples into a queue of timed mark and space durations in microseconds. A host drains the queue one 32-bit word at a time through a pop interface. The host sees an empty flag, a fill level and a sticky overflow flag.

Bytes enter over a valid/ready handshake. The block spends eight clock cycles on each byte, one per sample, so a run can span any number of bytes. A run is written to the queue only when the line level changes. Each duration carries a fixed correction of half a receiver frame. An end-of-sequence timer watches for activity. When it runs out, it sends two one-cycle requests: one restarts the receiver and one clears its receive FIFO.

Top module: `irrun_decoder`

## Requirements
- R1: Each accepted byte is inverted, then its bits are taken from bit 0 up to bit 7; an inverted 1 is a mark sample (carrier present) and an inverted 0 is a space sample.
- R2: Equal consecutive samples are counted across byte boundaries; when the level changes, the run of the previous level is queued and the count restarts at 1; a zero-length run (the level held since reset) is never queued; in_ready is low for the 8 cycles that follow an accepted byte.
- R3: The raw length of a run is round(count × 1,000,000 × DIVISOR / 115,200) microseconds, where DIVISOR is 1, 2, 4 or 8.
- R4: A mark is shortened by HALF = floor(floor(DIVISOR × 8,000,000 / 115,200) / 2) µs, which is 34 for DIVISOR 1; when the raw length is HALF or less, the result is 1.
- R5: A space is lengthened by HALF µs.
- R6: A queued word has bit 24 set for a mark and clear for a space, the duration in bits 23:0 (saturated at 0xFFFFFF), and bits 31:25 zero.
- R7: Accepting a byte that is nonzero after inversion (so any input byte except 0xFF) loads the timer with TIMEOUT_CYCLES. An input byte of 0xFF leaves the timer unchanged. The timer fires exactly TIMEOUT_CYCLES cycles after the last load. Firing gives one cycle of rx_restart and of fifo_clr together and disarms the timer.
- R8: The queue holds DEPTH entries (1024 by default); a run produced while the queue is full is discarded and the queued entries are kept unchanged.
- R9: ovf_flag is set when a run is discarded. It stays set until ovf_clear is high at a clock edge. If a discard and a clear fall on the same edge, the set wins.
- R10: Raising out_pop while out_empty is low removes the oldest entry; out_data shows it from the next cycle; out_level gives the current number of entries.
- R11: After reset the queue is empty, out_level is 0, ovf_flag is 0, in_ready is 1, and rx_restart and fifo_clr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Sample byte as received (inverted samples) |
| out_pop | input | 1 | Remove the oldest queued word |
| out_data | output | 32 | Popped word, valid the cycle after the pop |
| out_empty | output | 1 | Queue holds no words |
| out_level | output | $clog2(DEPTH)+1 | Number of queued words |
| ovf_flag | output | 1 | Sticky: a word was discarded |
| ovf_clear | input | 1 | Clears ovf_flag |
| rx_restart | output | 1 | One-cycle receiver disable/re-enable request |
| fifo_clr | output | 1 | One-cycle receive-FIFO clear request |

## Verification
A wrong run counter or level register shows up at the ports as a wrong duration or pulse flag in the next word popped. If the register holding the level goes wrong, the queue gains or loses a word, and the scoreboard finds this when it runs out of expected words or has some left over. A timer that is loaded wrongly fires some cycles too early or too late. A timer that is never disarmed fires a second time. The bench measures the firing cycle exactly against the cycle in which the byte was accepted. Queue faults come out only when the queue is full. If the write pointer moves on a discarded run, or the level is counted wrongly, the level reads wrong at once. In that case the words drained afterwards also differ from the oldest DEPTH entries.

// File: rtl/irrun_pkg.sv
package irrun_pkg;
  localparam int BYTE_W = 8;
  localparam int DUR_W  = 24;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic             mark;
    logic [DUR_W-1:0] dur;
  } ir_entry_t;

  localparam int ENTRY_W = $bits(ir_entry_t);
endpackage

// File: rtl/irrun_sampler.sv
module irrun_sampler
  import irrun_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              byte_live,
  output logic              run_valid,
  output logic              run_mark,
  output logic [CNT_W-1:0]  run_len
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              busy;
  logic [BYTE_W-1:0] samples;
  logic [IDX_W-1:0]  idx;
  logic              level;
  logic [CNT_W-1:0]  count;
  logic              accept;

  assign in_ready  = !busy;
  assign accept    = in_valid && !busy;
  assign byte_live = accept && (in_byte != '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      samples   <= '0;
      idx       <= '0;
      level     <= 1'b0;
      count     <= '0;
      run_valid <= 1'b0;
      run_mark  <= 1'b0;
      run_len   <= '0;
    end else begin
      run_valid <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        samples <= ~in_byte;
        idx     <= '0;
      end else if (busy) begin
        if (samples[0] == level) begin
          if (count != CNT_MAX) count <= count + 1'b1;
        end else begin
          if (count != '0) begin
            run_valid <= 1'b1;
            run_mark  <= level;
            run_len   <= count;
          end
          level <= samples[0];
          count <= CNT_W'(1);
        end
        samples <= samples >> 1;
        idx     <= idx + 1'b1;
        if (idx == IDX_W'(BYTE_W - 1)) busy <= 1'b0;
      end
    end
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready)
    else $error("byte accepted while still shifting");

  assert_emit_on_change_R2: assert property (@(posedge clk) disable iff (rst)
    run_valid |-> (run_mark != level) && (run_len != '0))
    else $error("run emitted without level change");
endmodule

// File: rtl/irrun_scale.sv
module irrun_scale
  import irrun_pkg::*;
#(
  parameter int DIVISOR = 1,
  parameter int CNT_W   = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_valid,
  input  logic             run_mark,
  input  logic [CNT_W-1:0] run_len,
  output logic             ent_valid,
  output ir_entry_t        ent
);
  localparam logic [63:0] USPS_Q16 =
    (64'(DIVISOR) * 64'd65536000000 + 64'd57600) / 64'd115200;
  localparam logic [63:0] HALF_US  = 64'((DIVISOR * 8000000 / 115200) / 2);
  localparam logic [63:0] DUR_MAX  = 64'((64'd1 << DUR_W) - 1);

  logic [63:0] prod, raw, adj;

  always_comb begin
    prod = 64'(run_len) * USPS_Q16;
    raw  = (prod + 64'd32768) >> 16;
    if (run_mark) adj = (raw > HALF_US) ? (raw - HALF_US) : 64'd1;
    else          adj = raw + HALF_US;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= 1'b0;
      ent       <= '0;
    end else begin
      ent_valid <= run_valid;
      if (run_valid) begin
        ent.mark <= run_mark;
        ent.dur  <= (adj > DUR_MAX) ? DUR_MAX[DUR_W-1:0] : adj[DUR_W-1:0];
      end
    end
  end

  assert_mark_floor_R4: assert property (@(posedge clk) disable iff (rst)
    ent_valid && ent.mark |-> ent.dur != '0)
    else $error("mark duration below floor");

  assert_space_bias_R5: assert property (@(posedge clk) disable iff (rst)
    ent_valid && !ent.mark |-> ent.dur >= HALF_US[DUR_W-1:0])
    else $error("space missing bias");
endmodule

// File: rtl/irrun_fifo.sv
module irrun_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 25
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [W-1:0]           wr_data,
  input  logic                   rd_en,
  output logic [W-1:0]           rd_data,
  output logic                   empty,
  output logic [$clog2(DEPTH):0] level,
  output logic                   ovf,
  input  logic                   ovf_clear
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, do_wr, do_rd;

  assign full  = (level == FULL_LVL);
  assign empty = (level == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (wr_en && full) ovf <= 1'b1;
      else if (ovf_clear) ovf <= 1'b0;
    end
  end

  assert_drop_keeps_full_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en && full && !rd_en |=> full)
    else $error("full queue changed on dropped write");

  assert_ovf_set_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en && full |=> ovf)
    else $error("drop did not set overflow");

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ovf && !ovf_clear |=> ovf)
    else $error("overflow flag lost");
endmodule

// File: rtl/irrun_eos_timer.sv
module irrun_eos_timer #(
  parameter int TIMEOUT_CYCLES = 5000000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic rx_restart,
  output logic fifo_clr
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic [TW-1:0] remain;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain     <= '0;
      armed      <= 1'b0;
      rx_restart <= 1'b0;
      fifo_clr   <= 1'b0;
    end else begin
      rx_restart <= 1'b0;
      fifo_clr   <= 1'b0;
      if (restart) begin
        remain <= TW'(TIMEOUT_CYCLES - 1);
        armed  <= 1'b1;
      end else if (armed) begin
        if (remain == '0) begin
          armed      <= 1'b0;
          rx_restart <= 1'b1;
          fifo_clr   <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end

  assert_fire_disarms_R7: assert property (@(posedge clk) disable iff (rst)
    rx_restart && !$past(restart) |-> !armed)
    else $error("timer still armed after firing");

  assert_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    rx_restart |=> !rx_restart)
    else $error("restart request longer than one cycle");
endmodule

// File: rtl/irrun_decoder.sv
module irrun_decoder
  import irrun_pkg::*;
#(
  parameter int DIVISOR        = 1,
  parameter int DEPTH          = 1024,
  parameter int CNT_W          = 24,
  parameter int TIMEOUT_CYCLES = 5000000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_byte,
  input  logic                   out_pop,
  output logic [31:0]            out_data,
  output logic                   out_empty,
  output logic [$clog2(DEPTH):0] out_level,
  output logic                   ovf_flag,
  input  logic                   ovf_clear,
  output logic                   rx_restart,
  output logic                   fifo_clr
);
  logic             byte_live;
  logic             run_valid, run_mark;
  logic [CNT_W-1:0] run_len;
  logic             ent_valid;
  ir_entry_t        ent;
  logic [ENTRY_W-1:0] head;

  irrun_sampler #(.CNT_W(CNT_W)) u_sampler (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .byte_live(byte_live), .run_valid(run_valid),
    .run_mark(run_mark), .run_len(run_len)
  );

  irrun_scale #(.DIVISOR(DIVISOR), .CNT_W(CNT_W)) u_scale (
    .clk(clk), .rst(rst), .run_valid(run_valid), .run_mark(run_mark),
    .run_len(run_len), .ent_valid(ent_valid), .ent(ent)
  );

  irrun_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(ent_valid), .wr_data(ent),
    .rd_en(out_pop), .rd_data(head), .empty(out_empty), .level(out_level),
    .ovf(ovf_flag), .ovf_clear(ovf_clear)
  );

  irrun_eos_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .restart(byte_live),
    .rx_restart(rx_restart), .fifo_clr(fifo_clr)
  );

  assign out_data = {{(WORD_W-ENTRY_W){1'b0}}, head};

  assert_pulse_pair_R7: assert property (@(posedge clk) disable iff (rst)
    rx_restart == fifo_clr)
    else $error("restart and clear requests split");
endmodule

// File: tb/irrun_decoder_test.sv
module irrun_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 1;
  localparam int DEPTH      = 1024;
  localparam int TMO        = 200;
  localparam int LVL_W      = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_byte = '0;
  logic out_pop = 1'b0;
  logic [31:0] out_data;
  logic out_empty;
  logic [LVL_W-1:0] out_level;
  logic ovf_flag, ovf_clear = 1'b0, rx_restart, fifo_clr;

  irrun_decoder #(.DIVISOR(DIV), .DEPTH(DEPTH), .CNT_W(24), .TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_pop(out_pop), .out_data(out_data), .out_empty(out_empty), .out_level(out_level),
    .ovf_flag(ovf_flag), .ovf_clear(ovf_clear), .rx_restart(rx_restart), .fifo_clr(fifo_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, t_acc = 0;
  int fire_cnt = 0, fire_cyc = 0, pair_err = 0, dropped = 0;
  bit mon_en = 1'b0, pend = 1'b0, done = 1'b0;
  logic [31:0] expq[$];
  bit m_lvl = 1'b0;
  int m_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(bit mark, int n);
    real us;
    int raw, half, d;
    us   = n * 1.0e6 * DIV / 115200.0;
    raw  = $rtoi(us + 0.5);
    half = (DIV * 8000000 / 115200) / 2;
    if (mark) d = (raw > half) ? raw - half : 1;
    else      d = raw + half;
    if (d > 32'hFFFFFF) d = 32'hFFFFFF;
    return {7'b0, mark, d[23:0]};
  endfunction

  // Bench model of R1/R2: samples after inversion, LSB first
  task automatic model_bits(logic [7:0] s);
    for (int i = 0; i < 8; i++) begin
      if (s[i] == m_lvl) m_cnt++;
      else begin
        if (m_cnt != 0) begin
          if (expq.size() < DEPTH) expq.push_back(exp_word(m_lvl, m_cnt));
          else dropped++;
        end
        m_lvl = s[i];
        m_cnt = 1;
      end
    end
  endtask

  // s is the sample pattern after inversion; the port gets ~s
  task automatic send(logic [7:0] s);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_byte  = ~s;
    in_valid = 1'b1;
    model_bits(s);
    @(posedge clk);
    #1;
    t_acc    = cyc;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    mon_en = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (expq.size() == 0 && out_empty && !pend) break;
    end
    chk(expq.size() == 0, "R2", "words still expected", expq.size(), 0);
  endtask

  // Scoreboard monitor (R3 R4 R5 R6 R10)
  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        pend = 1'b0;
        if (expq.size() == 0) chk(1'b0, "R2", "unexpected word", out_data, 0);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          chk(out_data == e, "R6", "queued word", out_data, e);
        end
      end
      out_pop = 1'b0;
      if (mon_en && !out_empty) begin
        out_pop = 1'b1;
        pend    = 1'b1;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rx_restart) begin
        fire_cnt++;
        fire_cyc = cyc;
        if (!fifo_clr) pair_err++;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int f0, t0, t2;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(out_empty == 1'b1, "R11", "out_empty", out_empty, 1);
    chk(out_level == '0, "R11", "out_level", out_level, 0);
    chk(ovf_flag == 1'b0, "R11", "ovf_flag", ovf_flag, 0);
    chk(in_ready == 1'b1, "R11", "in_ready", in_ready, 1);
    chk(!rx_restart && !fifo_clr, "R11", "requests", rx_restart, 0);

    // R2 busy window: in_ready low for 8 cycles after accept
    send(8'h0F);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R2", "in_ready while shifting", in_ready, 0);
    end
    @(negedge clk);
    chk(in_ready == 1'b1, "R2", "in_ready after byte", in_ready, 1);

    // Patterns: R1 R3 R4 R5 (floor, short marks, runs across bytes)
    mon_en = 1'b1;
    send(8'h00); send(8'hFF); send(8'hFF); send(8'h01);
    send(8'hAA); send(8'h55); send(8'h3C); send(8'h80);
    for (int j = 0; j < 40; j++) send(8'hFF);
    send(8'h00); send(8'h00); send(8'hF0); send(8'h01);
    drain();

    // R10 level while nothing is popped
    mon_en = 1'b0;
    repeat (3) @(negedge clk);
    send(8'h33); send(8'h66);
    repeat (12) @(negedge clk);
    chk(out_level == LVL_W'(expq.size()), "R10", "out_level", out_level, expq.size());
    chk(out_empty == 1'b0, "R10", "out_empty with words", out_empty, 0);
    drain();

    // R7 timer: exact firing cycle, 0xFF input ignored, single fire
    repeat (TMO + 50) @(negedge clk);
    f0 = fire_cnt;
    send(8'h01);
    t0 = t_acc;
    repeat (100) @(negedge clk);
    send(8'h00);
    while (cyc < t0 + 2 * TMO) @(negedge clk);
    chk(fire_cnt == f0 + 1, "R7", "fire count", fire_cnt, f0 + 1);
    chk(fire_cyc - t0 == TMO, "R7", "fire delay", fire_cyc - t0, TMO);
    send(8'h01);
    repeat (150) @(negedge clk);
    send(8'h02);
    t2 = t_acc;
    while (cyc < t2 + 2 * TMO) @(negedge clk);
    chk(fire_cnt == f0 + 2, "R7", "restart fire count", fire_cnt, f0 + 2);
    chk(fire_cyc - t2 == TMO, "R7", "restart delay", fire_cyc - t2, TMO);
    chk(pair_err == 0, "R7", "fifo_clr with rx_restart", pair_err, 0);
    drain();

    // R8 R9 overflow
    mon_en = 1'b0;
    repeat (3) @(negedge clk);
    dropped = 0;
    while (dropped < 4) send(8'h0F);
    repeat (12) @(negedge clk);
    chk(out_level == LVL_W'(DEPTH), "R8", "level when full", out_level, DEPTH);
    chk(ovf_flag == 1'b1, "R9", "ovf after drop", ovf_flag, 1);
    repeat (5) @(negedge clk);
    chk(ovf_flag == 1'b1, "R9", "ovf sticky", ovf_flag, 1);
    ovf_clear = 1'b1;
    @(posedge clk);
    #1 ovf_clear = 1'b0;
    @(negedge clk);
    chk(ovf_flag == 1'b0, "R9", "ovf after clear", ovf_flag, 0);
    drain();
    chk(out_empty == 1'b1, "R8", "empty after drain", out_empty, 1);

    finish_run();
  end
endmodule